// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash model. It watches bus write cycles, each one a single-clock `wr_en` pulse carrying an address and a data byte. It follows the multi-write unlock handshakes and raises a one-clock command strobe toward an external algorithm controller when a handshake completes. The strobes are reset, ID entry, program, chip erase, sector erase, suspend and resume. Program and sector erase strobes come with latched parameters.

The block tracks whether the memory is in ordinary read mode or in identification mode. While in identification mode it returns a fixed vendor byte, a fixed part byte or a per-sector protection byte for any read address. Two status inputs from the controller gate which writes are accepted: one marks a busy program, the other marks a running sector erase. A third input says that an erase is suspended. Any write that breaks a handshake returns the block to read mode without a strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every strobe output is low and `id_mode` is 0 (read mode).
- R2: Fixed unlock addresses are compared only on `wr_addr[10:0]` (0x555 and 0x2AA). Upper address bits do not affect matching.
- R3: The write sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 arms programming. The next write, with any data at any address, gives `stb_program` one clock after it is captured. That write's address and data appear on `prm_addr`/`prm_data`.
- R4: Any write with an address or data that is not a valid next step produces no strobe. It returns the sequence to its start and clears `id_mode`.
- R5: The sequence 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 pulses `stb_id` and sets `id_mode`. While `id_mode` is 1, `id_rdata` depends on `rd_addr`. With `rd_addr[1:0]`=00 it is 0xC2. With 01 it is 0xA4. With `rd_addr[1]`=1 it is 0x01 if `prot_map[rd_addr[18:16]]` is set, else 0x00.
- R6: Data 0xF0 at any address, written at any point outside an armed program step, pulses `stb_reset` and clears `id_mode`. This covers both the single-write form and the AA/55/F0 form.
- R7: After 0x80@0x555 in the third write, two further unlock writes must follow. A sixth write of 0x10@0x555 pulses `stb_chip_erase`. A sixth write of 0x30 at any address pulses `stb_sector_erase`, with `prm_sector` = that address's bits 18:16.
- R8: While `pgm_busy` is 1, every write is ignored. No strobe is produced and the sequence position and mode are unchanged.
- R9: While `erase_busy` is 1 and `pgm_busy` is 0, only data 0xB0 (any address) is accepted, and it pulses `stb_suspend`. All other writes are ignored.
- R10: Data 0x30 as a single write pulses `stb_resume` only while `erase_susp` is 1. Without an erase in progress or suspended, single writes of 0xB0 or 0x30 produce no strobe.
- R11: At most one strobe is high in any clock. A strobe is high only in the clock after a captured write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock bus write cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| pgm_busy | input | 1 | Program operation in progress |
| erase_busy | input | 1 | Sector erase actively running |
| erase_susp | input | 1 | Sector erase is suspended |
| rd_addr | input | 19 | Read address for identification reads |
| prot_map | input | 8 | Per-sector protection flags |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification read data (0 outside ID mode) |
| stb_reset | output | 1 | Reset command strobe |
| stb_id | output | 1 | ID entry strobe |
| stb_program | output | 1 | Program command strobe |
| stb_chip_erase | output | 1 | Chip erase strobe |
| stb_sector_erase | output | 1 | Sector erase strobe |
| stb_suspend | output | 1 | Erase suspend strobe |
| stb_resume | output | 1 | Erase resume strobe |
| prm_addr | output | 19 | Latched program or sector-erase address |
| prm_data | output | 8 | Latched program data |
| prm_sector | output | 3 | Latched target sector |

## Verification
The in-line properties check the following on every cycle:
- Strobes are mutually exclusive and appear only after a captured write.
- A write under `pgm_busy` leaves the sequence and mode untouched.
- Only a suspend can come out of a write during an active erase.
- A resume always traces back to a suspended erase.
- Entry into identification mode coincides with the ID strobe.

Only the bench scenarios can show the rest. These are that the full multi-write handshakes produce the right command with the right latched address, data and sector, and that broken handshakes fall silent. They also cover the identification read values and the fact that a write ignored under busy leaves no partial progress behind.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM_ARM,
        SQ_ERS_SET,
        SQ_ERS_UNL1,
        SQ_ERS_UNL2
    } seq_state_e;

    typedef struct packed {
        logic rst;
        logic id;
        logic pgm;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
    } strobe_t;

    localparam logic [7:0] BYTE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] BYTE_UNLOCK_B = 8'h55;
    localparam logic [7:0] BYTE_PROGRAM  = 8'hA0;
    localparam logic [7:0] BYTE_IDENT    = 8'h90;
    localparam logic [7:0] BYTE_ERS_SET  = 8'h80;
    localparam logic [7:0] BYTE_CHIP     = 8'h10;
    localparam logic [7:0] BYTE_SECT_RES = 8'h30;
    localparam logic [7:0] BYTE_SUSPEND  = 8'hB0;
    localparam logic [7:0] BYTE_RESET    = 8'hF0;

endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 11,
    parameter logic [CMP_W-1:0] ADR_FIRST  = 11'h555,
    parameter logic [CMP_W-1:0] ADR_SECOND = 11'h2AA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_aa,
    output logic              hit_55,
    output logic              hit_a0,
    output logic              hit_90,
    output logic              hit_80,
    output logic              hit_10,
    output logic              any_f0,
    output logic              any_b0,
    output logic              any_30
);
    import flash_cmd_pkg::*;

    logic at_first;
    logic at_second;

    always_comb begin
        at_first  = (addr[CMP_W-1:0] == ADR_FIRST);
        at_second = (addr[CMP_W-1:0] == ADR_SECOND);
        hit_aa    = at_first  && (data == DATA_W'(BYTE_UNLOCK_A));
        hit_55    = at_second && (data == DATA_W'(BYTE_UNLOCK_B));
        hit_a0    = at_first  && (data == DATA_W'(BYTE_PROGRAM));
        hit_90    = at_first  && (data == DATA_W'(BYTE_IDENT));
        hit_80    = at_first  && (data == DATA_W'(BYTE_ERS_SET));
        hit_10    = at_first  && (data == DATA_W'(BYTE_CHIP));
        any_f0    = (data == DATA_W'(BYTE_RESET));
        any_b0    = (data == DATA_W'(BYTE_SUSPEND));
        any_30    = (data == DATA_W'(BYTE_SECT_RES));
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    input  logic                  hit_aa,
    input  logic                  hit_55,
    input  logic                  hit_a0,
    input  logic                  hit_90,
    input  logic                  hit_80,
    input  logic                  hit_10,
    input  logic                  any_f0,
    input  logic                  any_b0,
    input  logic                  any_30,
    input  logic                  pgm_busy,
    input  logic                  erase_busy,
    input  logic                  erase_susp,
    output flash_cmd_pkg::strobe_t stb,
    output logic                  id_mode,
    output logic [ADDR_W-1:0]     par_addr,
    output logic [DATA_W-1:0]     par_data,
    output logic [SECT_W-1:0]     par_sector
);
    import flash_cmd_pkg::*;

    typedef struct packed {
        seq_state_e          st;
        logic                idm;
        strobe_t             stb;
        logic [ADDR_W-1:0]   pa;
        logic [DATA_W-1:0]   pd;
        logic [SECT_W-1:0]   sec;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d     = q;
        d.stb = '0;
        if (wr_en) begin
            if (pgm_busy) begin
                // writes have no effect while programming
            end else if (erase_busy) begin
                if (any_b0) begin
                    d.stb.susp = 1'b1;
                    d.st       = SQ_IDLE;
                end
            end else if (q.st == SQ_PGM_ARM) begin
                d.stb.pgm = 1'b1;
                d.pa      = addr;
                d.pd      = data;
                d.st      = SQ_IDLE;
            end else if (any_f0) begin
                d.stb.rst = 1'b1;
                d.idm     = 1'b0;
                d.st      = SQ_IDLE;
            end else if (q.st == SQ_IDLE && erase_susp && any_30) begin
                d.stb.resume = 1'b1;
            end else begin
                d.st = SQ_IDLE;
                unique case (q.st)
                    SQ_IDLE: begin
                        if (hit_aa) d.st = SQ_UNL1;
                        else        d.idm = 1'b0;
                    end
                    SQ_UNL1: begin
                        if (hit_55) d.st = SQ_UNL2;
                        else        d.idm = 1'b0;
                    end
                    SQ_UNL2: begin
                        if (hit_a0) begin
                            d.st = SQ_PGM_ARM;
                        end else if (hit_90) begin
                            d.idm    = 1'b1;
                            d.stb.id = 1'b1;
                        end else if (hit_80) begin
                            d.st = SQ_ERS_SET;
                        end else begin
                            d.idm = 1'b0;
                        end
                    end
                    SQ_ERS_SET: begin
                        if (hit_aa) d.st = SQ_ERS_UNL1;
                        else        d.idm = 1'b0;
                    end
                    SQ_ERS_UNL1: begin
                        if (hit_55) d.st = SQ_ERS_UNL2;
                        else        d.idm = 1'b0;
                    end
                    SQ_ERS_UNL2: begin
                        if (hit_10) begin
                            d.stb.chip = 1'b1;
                        end else if (any_30) begin
                            d.stb.sect = 1'b1;
                            d.pa       = addr;
                            d.sec      = addr[ADDR_W-1 -: SECT_W];
                        end else begin
                            d.idm = 1'b0;
                        end
                    end
                    default: d.idm = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= SQ_IDLE;
            q.idm <= 1'b0;
            q.stb <= '0;
            q.pa  <= '0;
            q.pd  <= '0;
            q.sec <= '0;
        end else begin
            q <= d;
        end
    end

    assign stb        = q.stb;
    assign id_mode    = q.idm;
    assign par_addr   = q.pa;
    assign par_data   = q.pd;
    assign par_sector = q.sec;

    // R11
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.stb));

    // R11
    stb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stb != '0) |-> $past(wr_en));

    // R8
    pgm_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pgm_busy) |=> (q.stb == '0 && $stable(q.st) && $stable(q.idm)));

    // R9
    erase_busy_only_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && erase_busy && !pgm_busy) |=>
            (!q.stb.rst && !q.stb.id && !q.stb.pgm && !q.stb.chip &&
             !q.stb.sect && !q.stb.resume));

    // R10
    resume_needs_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb.resume |-> $past(erase_susp));

    // R5
    id_entry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.idm) |-> q.stb.id);
endmodule

// File: rtl/fcd_idread.sv
module fcd_idread #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 8,
    parameter logic [DATA_W-1:0] VENDOR_CODE = 8'hC2,
    parameter logic [DATA_W-1:0] PART_CODE   = 8'hA4
) (
    input  logic                id_mode,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] prot_map,
    output logic [DATA_W-1:0]   rdata
);
    localparam int SECT_W = $clog2(NUM_SECT);

    logic [SECT_W-1:0] sect_idx;

    always_comb begin
        sect_idx = rd_addr[ADDR_W-1 -: SECT_W];
        rdata    = '0;
        if (id_mode) begin
            if (rd_addr[1])      rdata = DATA_W'(prot_map[sect_idx]);
            else if (rd_addr[0]) rdata = PART_CODE;
            else                 rdata = VENDOR_CODE;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CMP_W    = 11,
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                pgm_busy,
    input  logic                erase_busy,
    input  logic                erase_susp,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] prot_map,
    output logic                id_mode,
    output logic [DATA_W-1:0]   id_rdata,
    output logic                stb_reset,
    output logic                stb_id,
    output logic                stb_program,
    output logic                stb_chip_erase,
    output logic                stb_sector_erase,
    output logic                stb_suspend,
    output logic                stb_resume,
    output logic [ADDR_W-1:0]   prm_addr,
    output logic [DATA_W-1:0]   prm_data,
    output logic [SECT_W-1:0]   prm_sector
);
    import flash_cmd_pkg::*;

    logic hit_aa, hit_55, hit_a0, hit_90, hit_80, hit_10;
    logic any_f0, any_b0, any_30;
    strobe_t stb;

    fcd_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)
    ) u_match (
        .addr(wr_addr), .data(wr_data),
        .hit_aa(hit_aa), .hit_55(hit_55), .hit_a0(hit_a0),
        .hit_90(hit_90), .hit_80(hit_80), .hit_10(hit_10),
        .any_f0(any_f0), .any_b0(any_b0), .any_30(any_30)
    );

    fcd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(wr_addr), .data(wr_data),
        .hit_aa(hit_aa), .hit_55(hit_55), .hit_a0(hit_a0),
        .hit_90(hit_90), .hit_80(hit_80), .hit_10(hit_10),
        .any_f0(any_f0), .any_b0(any_b0), .any_30(any_30),
        .pgm_busy(pgm_busy), .erase_busy(erase_busy), .erase_susp(erase_susp),
        .stb(stb), .id_mode(id_mode),
        .par_addr(prm_addr), .par_data(prm_data), .par_sector(prm_sector)
    );

    fcd_idread #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT)
    ) u_idread (
        .id_mode(id_mode), .rd_addr(rd_addr), .prot_map(prot_map),
        .rdata(id_rdata)
    );

    assign stb_reset        = stb.rst;
    assign stb_id           = stb.id;
    assign stb_program      = stb.pgm;
    assign stb_chip_erase   = stb.chip;
    assign stb_sector_erase = stb.sect;
    assign stb_suspend      = stb.susp;
    assign stb_resume       = stb.resume;
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
    localparam logic [6:0] E_NONE = 7'b0000000;
    localparam logic [6:0] E_RST  = 7'b1000000;
    localparam logic [6:0] E_ID   = 7'b0100000;
    localparam logic [6:0] E_PGM  = 7'b0010000;
    localparam logic [6:0] E_CHIP = 7'b0001000;
    localparam logic [6:0] E_SECT = 7'b0000100;
    localparam logic [6:0] E_SUSP = 7'b0000010;
    localparam logic [6:0] E_RES  = 7'b0000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pgm_busy = 1'b0, erase_busy = 1'b0, erase_susp = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  prot_map = 8'b0010_0000;
    logic        id_mode;
    logic [7:0]  id_rdata;
    logic        s_rst, s_id, s_pgm, s_chip, s_sect, s_susp, s_res;
    logic [18:0] prm_addr;
    logic [7:0]  prm_data;
    logic [2:0]  prm_sector;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic wr_seen = 1'b0;

    typedef struct {
        logic [6:0]  stb;
        logic [18:0] a;
        logic [7:0]  d;
        int          req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pgm_busy(pgm_busy), .erase_busy(erase_busy),
        .erase_susp(erase_susp), .rd_addr(rd_addr), .prot_map(prot_map),
        .id_mode(id_mode), .id_rdata(id_rdata),
        .stb_reset(s_rst), .stb_id(s_id), .stb_program(s_pgm),
        .stb_chip_erase(s_chip), .stb_sector_erase(s_sect),
        .stb_suspend(s_susp), .stb_resume(s_res),
        .prm_addr(prm_addr), .prm_data(prm_data), .prm_sector(prm_sector)
    );

    always @(posedge clk) wr_seen <= wr_en;

    // monitor: compares the strobe vector one clock after every write
    always @(negedge clk) begin
        logic [6:0] got;
        exp_t e;
        got = {s_rst, s_id, s_pgm, s_chip, s_sect, s_susp, s_res};
        if (rst_n && wr_seen && sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (got !== e.stb) begin
                fails++;
                $display("FAIL R%0d strobes actual=%b expected=%b", e.req, got, e.stb);
            end else if (e.stb == E_PGM && (prm_addr !== e.a || prm_data !== e.d)) begin
                fails++;
                $display("FAIL R%0d program params actual=%h/%h expected=%h/%h",
                         e.req, prm_addr, prm_data, e.a, e.d);
            end else if (e.stb == E_SECT && prm_sector !== e.a[18:16]) begin
                fails++;
                $display("FAIL R%0d sector actual=%0d expected=%0d",
                         e.req, prm_sector, e.a[18:16]);
            end
        end else if (rst_n && !wr_seen && got != E_NONE) begin
            checks++;
            fails++;
            // R11
            $display("FAIL R11 strobe without write actual=%b expected=%b", got, E_NONE);
        end
    end

    task automatic wr(input logic [18:0] a, input logic [7:0] d,
                      input logic [6:0] es, input int req);
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        e.stb = es; e.a = a; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic chk_mode(input logic exp, input int req);
        checks++;
        if (id_mode !== exp) begin
            fails++;
            $display("FAIL R%0d id_mode actual=%b expected=%b", req, id_mode, exp);
        end
    endtask

    task automatic chk_id(input logic [18:0] ra, input logic [7:0] exp, input int req);
        rd_addr = ra;
        #1;
        checks++;
        if (id_rdata !== exp) begin
            fails++;
            $display("FAIL R%0d id_rdata@%h actual=%h expected=%h", req, ra, id_rdata, exp);
        end
    endtask

    task automatic enter_id();
        wr(19'h00555, 8'hAA, E_NONE, 5);
        wr(19'h002AA, 8'h55, E_NONE, 5);
        wr(19'h00555, 8'h90, E_ID, 5);
        idle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if ({s_rst, s_id, s_pgm, s_chip, s_sect, s_susp, s_res} !== E_NONE || id_mode !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=0/0",
                     {s_rst, s_id, s_pgm, s_chip, s_sect, s_susp, s_res}, id_mode);
        end
        rst_n = 1'b1;
        idle(2);

        // R2 R3 program with upper address bits set in the unlock writes
        wr(19'h78555, 8'hAA, E_NONE, 2);
        wr(19'h3F2AA, 8'h55, E_NONE, 2);
        wr(19'h50555, 8'hA0, E_NONE, 3);
        wr(19'h41234, 8'h5A, E_PGM, 3);
        idle(2);
        // R3 program data F0 is still data
        wr(19'h00555, 8'hAA, E_NONE, 3);
        wr(19'h002AA, 8'h55, E_NONE, 3);
        wr(19'h00555, 8'hA0, E_NONE, 3);
        wr(19'h7FFFF, 8'hF0, E_PGM, 3);
        idle(2);

        // R5 identification reads
        enter_id();
        chk_mode(1'b1, 5);
        chk_id(19'h00000, 8'hC2, 5);
        chk_id(19'h00001, 8'hA4, 5);
        chk_id(19'h50002, 8'h01, 5);
        chk_id(19'h20002, 8'h00, 5);

        // R6 single-write reset
        wr(19'h12345, 8'hF0, E_RST, 6);
        idle(2);
        chk_mode(1'b0, 6);
        chk_id(19'h00000, 8'h00, 5);

        // R6 three-write reset
        enter_id();
        wr(19'h00555, 8'hAA, E_NONE, 6);
        wr(19'h002AA, 8'h55, E_NONE, 6);
        wr(19'h00555, 8'hF0, E_RST, 6);
        idle(2);
        chk_mode(1'b0, 6);

        // R4 wrong address breaks the sequence; the A0 that follows arms nothing
        wr(19'h00555, 8'hAA, E_NONE, 4);
        wr(19'h002AB, 8'h55, E_NONE, 4);
        wr(19'h00555, 8'hA0, E_NONE, 4);
        wr(19'h01000, 8'h33, E_NONE, 4);
        idle(2);
        // R4 wrong data in ID mode returns to read mode
        enter_id();
        wr(19'h00000, 8'h12, E_NONE, 4);
        idle(2);
        chk_mode(1'b0, 4);

        // R7 chip erase
        wr(19'h00555, 8'hAA, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h00555, 8'h80, E_NONE, 7);
        wr(19'h00555, 8'hAA, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h00555, 8'h10, E_CHIP, 7);
        idle(2);
        // R7 sector erase in sector 6
        wr(19'h00555, 8'hAA, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h00555, 8'h80, E_NONE, 7);
        wr(19'h00555, 8'hAA, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h60100, 8'h30, E_SECT, 7);
        idle(2);
        // R7 erase setup with wrong fourth write
        wr(19'h00555, 8'hAA, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h00555, 8'h80, E_NONE, 7);
        wr(19'h002AA, 8'h55, E_NONE, 7);
        wr(19'h00555, 8'h10, E_NONE, 7);
        idle(2);

        // R8 writes under pgm_busy leave no progress
        @(negedge clk) pgm_busy = 1'b1;
        wr(19'h00000, 8'hF0, E_NONE, 8);
        wr(19'h00555, 8'hAA, E_NONE, 8);
        wr(19'h002AA, 8'h55, E_NONE, 8);
        idle(2);
        @(negedge clk) pgm_busy = 1'b0;
        wr(19'h00555, 8'hA0, E_NONE, 8);
        wr(19'h00100, 8'h77, E_NONE, 8);
        idle(2);
        // R8 mode kept under pgm_busy
        enter_id();
        @(negedge clk) pgm_busy = 1'b1;
        wr(19'h00000, 8'hF0, E_NONE, 8);
        idle(2);
        chk_mode(1'b1, 8);
        @(negedge clk) pgm_busy = 1'b0;
        wr(19'h00000, 8'hF0, E_RST, 6);
        idle(2);

        // R9 only suspend during active erase
        @(negedge clk) erase_busy = 1'b1;
        wr(19'h00000, 8'hF0, E_NONE, 9);
        wr(19'h00555, 8'hAA, E_NONE, 9);
        wr(19'h002AA, 8'h55, E_NONE, 9);
        wr(19'h00555, 8'h90, E_NONE, 9);
        wr(19'h30000, 8'h30, E_NONE, 9);
        wr(19'h12345, 8'hB0, E_SUSP, 9);
        idle(2);
        chk_mode(1'b0, 9);

        // R10 resume while suspended, program allowed while suspended
        @(negedge clk) begin erase_busy = 1'b0; erase_susp = 1'b1; end
        wr(19'h00555, 8'hAA, E_NONE, 10);
        wr(19'h002AA, 8'h55, E_NONE, 10);
        wr(19'h00555, 8'hA0, E_NONE, 10);
        wr(19'h20010, 8'h30, E_PGM, 10);
        idle(2);
        wr(19'h44444, 8'h30, E_RES, 10);
        idle(2);
        // R10 no erase context: B0 and 30 are ignored
        @(negedge clk) erase_susp = 1'b0;
        wr(19'h00000, 8'hB0, E_NONE, 10);
        wr(19'h00000, 8'h30, E_NONE, 10);
        idle(2);

        // R11 back-to-back single-write commands each give one strobe
        wr(19'h00000, 8'hF0, E_RST, 11);
        wr(19'h00001, 8'hF0, E_RST, 11);
        idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule